// File: doc/BRIEF.md
# Shutter Setting Interface and Decoder

This block turns the camera's shutter configuration into the two values that the exposure counter consumes: a 2-bit shutter mode and a 9-bit load value. The configuration arrives by one of two routes, chosen by the `serSel` input. In parallel mode, two mode pins and three speed pins are decoded each clock through fixed per-mode tables. In serial mode, a slow three-wire interface (clock, data, strobe) shifts in a 12-bit word, which is committed to the working register on the strobe.

The serial wires are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are found in the system clock domain. In serial mode the two mode bits carried inside the word take the place of the mode pins. If a strobe arrives before a full word has been shifted in, the block still commits the partial contents and raises a flag that stays up until the next complete commit.

Top module: `shtr_setting_top`

## Requirements
- R1: After reset the mode output is 11 (shutter off), the load output is 0x000 and the short-word flag is 0.
- R2: In parallel mode (`serSel`=0) with mode pins 00 (flickerless), the outputs become mode 00 and load 0x149 one clock after the pins are sampled.
- R3: In parallel mode with mode pins 01 (high-speed), the speed code {spdPin[2],spdPin[1],spdPin[0]} maps to load values as follows: 111→0x1FF (1/50 s), 110→0x143, 101→0x105, 100→0x0E6, 011→0x0D6, 010→0x0CE, 001→0x0CA, 000→0x0C8.
- R4: In parallel mode with mode pins 10 (low-speed), the load is 0x1F7 plus the speed code, so 111 gives 0x1FE (2 fields) and 000 gives 0x1F7 (16 fields).
- R5: In parallel mode with mode pins 11 (off), the outputs are mode 11 and load 0x000.
- R6: In serial mode, data bits are taken on rising edges of the serial clock, first bit first. On a rising strobe edge, word bits 0..8 become the load (bit 0 as its LSB), bit 9 becomes mode[1] and bit 10 becomes mode[0]. Bit 11 is a dummy and is discarded. The new values appear within five clocks of the strobe rising.
- R7: In serial mode the mode pins and speed pins have no effect on the outputs.
- R8: In serial mode the outputs hold their values while bits are being shifted in, and change only on a strobe.
- R9: A strobe after fewer than 12 serial clock rises since the previous strobe still commits the last twelve shifted bits, with the newest bit at position 11, and sets the short-word flag. A strobe after 12 or more rises clears the flag.

Shutter mode encoding used everywhere: 00 flickerless, 01 high-speed, 10 low-speed, 11 off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serSel | input | 1 | 1 selects the serial setting path, 0 the parallel path |
| modePin | input | 2 | Parallel shutter mode pins (encoding as above) |
| spdPin | input | 3 | Parallel speed code pins |
| sclkPin | input | 1 | Serial shift clock, asynchronous |
| sdatPin | input | 1 | Serial data, asynchronous |
| stbPin | input | 1 | Serial commit strobe, asynchronous |
| shtrMode | output | 2 | Registered shutter mode |
| loadVal | output | 9 | Registered exposure counter load value |
| shortWord | output | 1 | Set when the last serial commit had fewer than 12 bits |

## Verification
The parallel results are due one clock after the pins are sampled. The bench changes the pins on a falling edge and reads the outputs at the second falling edge after that. A serial wire edge takes two synchroniser flops and one edge-detect compare, so a shift or a commit lands on the third rising clock after the wire changes. The bench holds each serial level for three clocks and waits several clocks after the strobe before comparing. It also checks the outputs just before the strobe, so any early change of the outputs in serial mode is caught.

// File: rtl/shtr_pkg.sv
package shtr_pkg;
  localparam int LOAD_W = 9;
  localparam int WORD_W = 12;
  localparam int SPD_W  = 3;

  typedef enum logic [1:0] {
    MODE_FLK  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_OFF  = 2'b11
  } shtrMode_e;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic shift;
    logic commit;
    logic shortWord;
  } seqStrobe_t;
endpackage

// File: rtl/shtr_ctrl.sv
module shtr_ctrl
  import shtr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NBITS       = WORD_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serSel,
  input  logic       sclkPin,
  input  logic       sdatPin,
  input  logic       stbPin,
  output seqStrobe_t strb,
  output logic       sdatBit
);
  localparam int CNT_W = $clog2(NBITS + 1);

  logic [2:0] rawIn;
  logic [2:0] syncQ [SYNC_STAGES];
  logic [2:0] syncOut;
  logic [1:0] prevQ;
  logic       clkRise, stbRise;
  logic [CNT_W-1:0] bitCnt;

  assign rawIn = {stbPin, sclkPin, sdatPin};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= syncOut[2:1];
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign sdatBit = syncOut[0];
  assign clkRise = syncOut[1] & ~prevQ[0];
  assign stbRise = syncOut[2] & ~prevQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) bitCnt <= '0;
    else if (serSel && stbRise) bitCnt <= '0;
    else if (serSel && clkRise && bitCnt != CNT_W'(NBITS)) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strb.shift     = serSel & clkRise;
    strb.commit    = serSel & stbRise;
    strb.shortWord = (bitCnt < CNT_W'(NBITS));
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(NBITS)); // R9
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit); // R6
endmodule

// File: rtl/shtr_dp.sv
module shtr_dp
  import shtr_pkg::*;
#(
  parameter int LW = LOAD_W,
  parameter int WW = WORD_W,
  parameter int SW = SPD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serSel,
  input  logic [1:0]    modePin,
  input  logic [SW-1:0] spdPin,
  input  seqStrobe_t    strb,
  input  logic          sdatBit,
  output logic [1:0]    shtrMode,
  output logic [LW-1:0] loadVal,
  output logic          shortWord
);
  localparam int MODE_HI_POS = LW;
  localparam int MODE_LO_POS = LW + 1;
  localparam logic [LW-1:0] FLK_LOAD  = LW'(9'h149);
  localparam logic [LW-1:0] SLOW_BASE = LW'(9'h1F7);

  logic [WW-1:0] shiftReg;
  logic [LW-1:0] parLoad;
  logic [1:0]    parMode;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {sdatBit, shiftReg[WW-1:1]};
  end

  always_comb begin
    parMode = modePin;
    unique case (shtrMode_e'(modePin))
      MODE_FLK:  parLoad = FLK_LOAD;
      MODE_FAST: begin
        unique case (spdPin)
          3'b111:  parLoad = LW'(9'h1FF);
          3'b110:  parLoad = LW'(9'h143);
          3'b101:  parLoad = LW'(9'h105);
          3'b100:  parLoad = LW'(9'h0E6);
          3'b011:  parLoad = LW'(9'h0D6);
          3'b010:  parLoad = LW'(9'h0CE);
          3'b001:  parLoad = LW'(9'h0CA);
          default: parLoad = LW'(9'h0C8);
        endcase
      end
      MODE_SLOW: parLoad = SLOW_BASE + LW'(spdPin);
      default:   parLoad = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shtrMode  <= MODE_OFF;
      loadVal   <= '0;
      shortWord <= 1'b0;
    end else if (!serSel) begin
      shtrMode <= parMode;
      loadVal  <= parLoad;
    end else if (strb.commit) begin
      shtrMode  <= {shiftReg[MODE_HI_POS], shiftReg[MODE_LO_POS]};
      loadVal   <= shiftReg[LW-1:0];
      shortWord <= strb.shortWord;
    end
  end

  AST_PAR_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    !serSel |=> shtrMode == $past(modePin)); // R2
  AST_SLOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!serSel && modePin == 2'b10) |=> loadVal >= SLOW_BASE); // R4
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!serSel && modePin == 2'b11) |=> loadVal == '0); // R5
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (serSel && !strb.commit) |=> ($stable(shtrMode) && $stable(loadVal))); // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (shortWord != $past(shortWord)) |-> $past(strb.commit)); // R9
endmodule

// File: rtl/shtr_setting_top.sv
module shtr_setting_top
  import shtr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             serSel,
  input  logic [1:0]       modePin,
  input  logic [SPD_W-1:0] spdPin,
  input  logic             sclkPin,
  input  logic             sdatPin,
  input  logic             stbPin,
  output logic [1:0]       shtrMode,
  output logic [LOAD_W-1:0] loadVal,
  output logic             shortWord
);
  seqStrobe_t strb;
  logic       sdatBit;

  shtr_ctrl #(.SYNC_STAGES(2), .NBITS(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .serSel(serSel),
    .sclkPin(sclkPin), .sdatPin(sdatPin), .stbPin(stbPin),
    .strb(strb), .sdatBit(sdatBit)
  );

  shtr_dp #(.LW(LOAD_W), .WW(WORD_W), .SW(SPD_W)) uDp (
    .clk(clk), .rstN(rstN), .serSel(serSel),
    .modePin(modePin), .spdPin(spdPin),
    .strb(strb), .sdatBit(sdatBit),
    .shtrMode(shtrMode), .loadVal(loadVal), .shortWord(shortWord)
  );
endmodule

// File: tb/shtr_setting_top_test.sv
module shtr_setting_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serSel = 1'b0;
  logic [1:0] modePin = 2'b11;
  logic [2:0] spdPin = 3'b111;
  logic sclkPin = 1'b0, sdatPin = 1'b0, stbPin = 1'b0;
  logic [1:0] shtrMode;
  logic [8:0] loadVal;
  logic shortWord;
  int nRun = 0, nFail = 0;
  logic [11:0] hist = '0;

  always #4 clk = ~clk;

  shtr_setting_top uut (
    .clk(clk), .rstN(rstN), .serSel(serSel), .modePin(modePin), .spdPin(spdPin),
    .sclkPin(sclkPin), .sdatPin(sdatPin), .stbPin(stbPin),
    .shtrMode(shtrMode), .loadVal(loadVal), .shortWord(shortWord)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [8:0] fastLoad(input logic [2:0] c);
    case (c)
      3'b111: return 9'h1FF; 3'b110: return 9'h143;
      3'b101: return 9'h105; 3'b100: return 9'h0E6;
      3'b011: return 9'h0D6; 3'b010: return 9'h0CE;
      3'b001: return 9'h0CA; default: return 9'h0C8;
    endcase
  endfunction

  task automatic sendBit(input logic b);
    sdatPin = b; waitN(3);
    sclkPin = 1'b1; waitN(3);
    sclkPin = 1'b0; waitN(3);
    hist = {b, hist[11:1]};
  endtask

  task automatic strobe();
    stbPin = 1'b1; waitN(3);
    stbPin = 1'b0; waitN(4);
  endtask

  task automatic sendWord(input logic [11:0] w);
    for (int i = 0; i < 12; i++) sendBit(w[i]);
  endtask

  task automatic tReset();
    waitN(3);
    chk("R1 mode", 16'(shtrMode), 16'h3);
    chk("R1 load", 16'(loadVal), 16'h0);
    chk("R1 flag", 16'(shortWord), 16'h0);
    rstN = 1'b1; waitN(1);
  endtask

  task automatic tParFlicker();
    modePin = 2'b00; spdPin = 3'b010; waitN(2);
    chk("R2 mode", 16'(shtrMode), 16'h0);
    chk("R2 load", 16'(loadVal), 16'h149);
  endtask

  task automatic tParFast();
    modePin = 2'b01;
    for (int c = 0; c < 8; c++) begin
      spdPin = 3'(c); waitN(2);
      chk("R3 mode", 16'(shtrMode), 16'h1);
      chk("R3 load", 16'(loadVal), 16'(fastLoad(3'(c))));
    end
  endtask

  task automatic tParSlow();
    modePin = 2'b10;
    for (int c = 0; c < 8; c++) begin
      spdPin = 3'(c); waitN(2);
      chk("R4 load", 16'(loadVal), 16'(9'h1F7 + 9'(c)));
    end
    chk("R4 mode", 16'(shtrMode), 16'h2);
  endtask

  task automatic tParOff();
    modePin = 2'b11; spdPin = 3'b000; waitN(2);
    chk("R5 mode", 16'(shtrMode), 16'h3);
    chk("R5 load", 16'(loadVal), 16'h0);
  endtask

  task automatic tSerialBasic();
    // dummy=1, mode bit10=1, bit9=0, load 0x0D6 -> mode 01
    serSel = 1'b1; modePin = 2'b00; waitN(2);
    sendWord({1'b1, 1'b1, 1'b0, 9'h0D6});
    chk("R8 hold before strobe", 16'(loadVal), 16'h0);
    strobe();
    chk("R6 load", 16'(loadVal), 16'h0D6);
    chk("R6 mode", 16'(shtrMode), 16'h1);
    chk("R9 full clears flag", 16'(shortWord), 16'h0);
  endtask

  task automatic tSerialPins();
    modePin = 2'b11; spdPin = 3'b000;
    sendWord({1'b0, 1'b0, 1'b1, 9'h1FA});
    chk("R7 pins ignored mode", 16'(shtrMode), 16'h1);
    chk("R8 hold load", 16'(loadVal), 16'h0D6);
    strobe();
    chk("R6 mode from word", 16'(shtrMode), 16'h2);
    chk("R7 load from word", 16'(loadVal), 16'h1FA);
    modePin = 2'b01; waitN(4);
    chk("R7 pin change ignored", 16'(shtrMode), 16'h2);
  endtask

  task automatic tShort();
    logic [11:0] expW;
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    expW = hist;
    strobe();
    chk("R9 flag set", 16'(shortWord), 16'h1);
    chk("R9 partial load", 16'(loadVal), 16'(expW[8:0]));
    chk("R9 partial mode", 16'(shtrMode), 16'({expW[9], expW[10]}));
    sendWord({1'b0, 1'b1, 1'b1, 9'h0C8});
    strobe();
    chk("R9 flag cleared", 16'(shortWord), 16'h0);
    chk("R6 mode 11", 16'(shtrMode), 16'h3);
    chk("R6 load", 16'(loadVal), 16'h0C8);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    tReset();
    tParFlicker();
    tParFast();
    tParSlow();
    tParOff();
    tSerialBasic();
    tSerialPins();
    tShort();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule